// File: doc/BRIEF.md
# Windowed Deadman Timer with Two-Key Keep-Alive

This block is a register-mapped deadman timer. Once software turns it on, a counter advances by one every clock. Software must restart the counter before it reaches a programmed period. A restart takes two writes in a fixed order. First an arming key goes to the pre-clear register, at any time. Then a restart key goes to the clear register, and that write is honoured only while the clear window is open. The window opens when the counter reaches a programmed interval, and it closes when the counter reaches the period.

A wrong arming key raises one error flag. A clear attempt that is out of order, out of window or carries a wrong key raises a second error flag and is treated as a deadman event. Reaching the period without a restart is also a deadman event. Every deadman event sets a sticky event flag and drives a one-cycle reset request towards the system reset controller, which records the cause. Status flags are cleared by writing ones to them.

Turning the timer off clears the counter. In the cycle right after the write that turns it off, the register bus is ignored.

Top module: `dmt_wdog`

## Requirements
- R1: After reset the control word, counter and status read 0, `rst_req` is low, and the period and interval registers read their parameter defaults (1000 and 500 with default parameters).
- R2: Writing the control register (offset 0x00) with bit 15 set turns the timer on. Bit 15 reads back. While the timer is on and no restart or expiry happens, the counter (offset 0x40) grows by exactly one per clock, starting from 0.
- R3: While the timer is off the counter is held at 0. In the one cycle after a write that turns a running timer off, bus accesses are ignored: writes have no effect and reads return 0.
- R4: Status bit 0 (offset 0x30) reads 1 exactly when the timer is on and interval <= counter < period.
- R5: A pre-clear write (offset 0x10) while on arms the restart when bits [15:8] equal 0x40. Any other value sets status bit 7 and disarms.
- R6: A clear write (offset 0x20) whose bits [7:0] equal 0x08, made while armed and with the window open, sets the counter to 0 on the next cycle. It also disarms the restart and raises no flag and no reset request.
- R7: A clear write while on that has a wrong key, no prior arming, or a closed window sets status bits 6 and 5, pulses `rst_req` for one cycle and disarms.
- R8: When the counter of a running timer reaches the period, status bit 5 is set, `rst_req` pulses for one cycle, the counter restarts from 0 and the restart is disarmed.
- R9: Writing the status register clears each of bits 7, 6 and 5 that is written as 1. A flag being set in the same cycle stays set.
- R10: Pre-clear and clear writes made while the timer is off have no effect on flags, arming or `rst_req`.
- R11: The period (offset 0x60) and interval (offset 0x70) registers are readable and writable. The counter register is read-only, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle; 0 when no read or when ignored |
| rst_req | output | 1 | One-cycle reset request on a deadman event |

## Verification
Read data is combinational, so it is due in the same cycle as the read access. Every register, flag and arming effect of a write shows one clock after the edge that takes the write. `rst_req` is high during the cycle that follows the edge where the expiry or bad clear was seen. The bench drives each access just after a falling edge and compares the outputs 1 ns later against a behavioural model. It then advances that model at the rising edge, so every expected value is taken in exactly the cycle these latencies give.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_PRE  = 8'h10;
  localparam logic [7:0] OFS_CLR  = 8'h20;
  localparam logic [7:0] OFS_STAT = 8'h30;
  localparam logic [7:0] OFS_CNT  = 8'h40;
  localparam logic [7:0] OFS_PER  = 8'h60;
  localparam logic [7:0] OFS_WIN  = 8'h70;

  localparam logic [7:0] KEY_ARM  = 8'h40;
  localparam logic [7:0] KEY_KICK = 8'h08;

  localparam int EN_BIT  = 15;
  localparam int ST_OPEN = 0;
  localparam int ST_EVT  = 5;
  localparam int ST_BAD2 = 6;
  localparam int ST_BAD1 = 7;

  function automatic logic arm_key_ok(logic [7:0] k);
    return k == KEY_ARM;
  endfunction

  function automatic logic kick_key_ok(logic [7:0] k);
    return k == KEY_KICK;
  endfunction

  function automatic logic in_window(logic [31:0] c, logic [31:0] lo, logic [31:0] hi);
    return (c >= lo) && (c < hi);
  endfunction

  function automatic logic reached(logic [31:0] c, logic [31:0] lim);
    return c >= lim;
  endfunction

  function automatic logic [DATA_W-1:0] stat_word(logic b1, logic b2, logic ev, logic open);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ST_BAD1] = b1;
    w[ST_BAD2] = b2;
    w[ST_EVT]  = ev;
    w[ST_OPEN] = open;
    return w;
  endfunction
endpackage

// File: rtl/dmt_count.sv
module dmt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] cnt,
  output logic             win_open,
  output logic             expire
);
  import dmt_pkg::*;

  always_comb begin
    win_open = en && in_window(32'(cnt), 32'(interval), 32'(period));
    expire   = en && reached(32'(cnt), 32'(period));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!en || restart || expire) cnt <= '0;
    else                               cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/dmt_keyseq.sv
module dmt_keyseq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pre_wr,
  input  logic       clr_wr,
  input  logic [7:0] arm_key,
  input  logic [7:0] kick_key,
  input  logic       win_open,
  input  logic       expire,
  output logic       armed,
  output logic       good_clr,
  output logic       bad_pre,
  output logic       bad_clr
);
  import dmt_pkg::*;

  always_comb begin
    bad_pre  = pre_wr && !arm_key_ok(arm_key);
    good_clr = clr_wr && kick_key_ok(kick_key) && armed && win_open;
    bad_clr  = clr_wr && !good_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 armed <= 1'b0;
    else if (!en)               armed <= 1'b0;
    else if (expire || clr_wr)  armed <= 1'b0;
    else if (pre_wr)            armed <= !bad_pre;
  end
endmodule

// File: rtl/dmt_flags.sv
module dmt_flags #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_v,
  input  logic [NFLAG-1:0] clr_v,
  input  logic             req_in,
  output logic [NFLAG-1:0] flags,
  output logic             rst_req
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set_v[i] | (flags[i] & ~clr_v[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= req_in;
  end
endmodule

// File: rtl/dmt_wdog.sv
module dmt_wdog #(
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int DEF_PERIOD = 1000,
  parameter int DEF_WIN    = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  import dmt_pkg::*;

  localparam int FL_B1 = 2;
  localparam int FL_B2 = 1;
  localparam int FL_EV = 0;

  logic             en_q, blank_q;
  logic [CNT_W-1:0] per_q, win_q, cnt;
  logic             acc, wr, rd;
  logic             pre_wr, clr_wr, st_wr;
  logic             win_open, expire, armed, good_clr, bad_pre, bad_clr;
  logic [2:0]       set_v, clr_v, flags;
  logic             bad1, bad2, evt;

  function automatic logic hit(logic [ADDR_W-1:0] a, logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    acc    = bus_sel && !blank_q;
    wr     = acc && bus_we;
    rd     = acc && !bus_we;
    pre_wr = wr && hit(bus_addr, OFS_PRE) && en_q;
    clr_wr = wr && hit(bus_addr, OFS_CLR) && en_q;
    st_wr  = wr && hit(bus_addr, OFS_STAT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      blank_q <= 1'b0;
      per_q   <= CNT_W'(DEF_PERIOD);
      win_q   <= CNT_W'(DEF_WIN);
    end else begin
      blank_q <= wr && hit(bus_addr, OFS_CTRL) && en_q && !bus_wdata[EN_BIT];
      if (wr && hit(bus_addr, OFS_CTRL)) en_q  <= bus_wdata[EN_BIT];
      if (wr && hit(bus_addr, OFS_PER))  per_q <= bus_wdata[CNT_W-1:0];
      if (wr && hit(bus_addr, OFS_WIN))  win_q <= bus_wdata[CNT_W-1:0];
    end
  end

  dmt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .restart(good_clr),
    .period(per_q), .interval(win_q), .cnt(cnt),
    .win_open(win_open), .expire(expire)
  );

  dmt_keyseq u_keys (
    .clk(clk), .rst_n(rst_n), .en(en_q), .pre_wr(pre_wr), .clr_wr(clr_wr),
    .arm_key(bus_wdata[15:8]), .kick_key(bus_wdata[7:0]),
    .win_open(win_open), .expire(expire), .armed(armed),
    .good_clr(good_clr), .bad_pre(bad_pre), .bad_clr(bad_clr)
  );

  always_comb begin
    set_v        = '0;
    set_v[FL_B1] = bad_pre;
    set_v[FL_B2] = bad_clr;
    set_v[FL_EV] = bad_clr || expire;
    clr_v        = '0;
    clr_v[FL_B1] = st_wr && bus_wdata[ST_BAD1];
    clr_v[FL_B2] = st_wr && bus_wdata[ST_BAD2];
    clr_v[FL_EV] = st_wr && bus_wdata[ST_EVT];
  end

  dmt_flags #(.NFLAG(3)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v),
    .req_in(bad_clr || expire), .flags(flags), .rst_req(rst_req)
  );

  assign bad1 = flags[FL_B1];
  assign bad2 = flags[FL_B2];
  assign evt  = flags[FL_EV];

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit(bus_addr, OFS_CTRL))      bus_rdata[EN_BIT] = en_q;
      else if (hit(bus_addr, OFS_STAT)) bus_rdata = stat_word(bad1, bad2, evt, win_open);
      else if (hit(bus_addr, OFS_CNT))  bus_rdata = 32'(cnt);
      else if (hit(bus_addr, OFS_PER))  bus_rdata = 32'(per_q);
      else if (hit(bus_addr, OFS_WIN))  bus_rdata = 32'(win_q);
    end
  end
endmodule

// File: rtl/dmt_wdog_chk.sv
module dmt_wdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             blank_q,
  input logic [CNT_W-1:0] cnt,
  input logic             win_open,
  input logic             expire,
  input logic             good_clr,
  input logic             bad_pre,
  input logic             bad_clr,
  input logic             bad1,
  input logic             evt,
  input logic             rst_req
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !expire && !good_clr |=> cnt == $past(cnt) + CNT_W'(1));

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> cnt == '0);

  p_blank_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |=> !blank_q);

  p_window_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> !expire);

  p_bad_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pre |=> bad1);

  p_clear_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    good_clr |=> cnt == '0 && !rst_req);

  p_bad_clear_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_clr |=> rst_req && evt);

  p_expire_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> rst_req && evt && cnt == '0);

  p_req_has_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> evt);
endmodule

bind dmt_wdog dmt_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .blank_q(blank_q), .cnt(cnt),
  .win_open(win_open), .expire(expire), .good_clr(good_clr),
  .bad_pre(bad_pre), .bad_clr(bad_clr), .bad1(bad1), .evt(evt),
  .rst_req(rst_req)
);

// File: tb/sim_dmt_wdog.sv
module sim_dmt_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int P_DEF = 1000;
  localparam int W_DEF = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_en, m_cnt, m_per, m_win, m_armed, m_b1, m_b2, m_ev, m_rq, m_blank;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmt_wdog #(.CNT_W(32), .ADDR_W(8), .DEF_PERIOD(P_DEF), .DEF_WIN(W_DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req)
  );

  function automatic int m_open();
    return (m_en != 0 && m_cnt >= m_win && m_cnt < m_per) ? 1 : 0;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00:   return (m_en != 0) ? 32'h8000 : 32'h0;
      8'h30:   return 32'((m_b1 << 7) | (m_b2 << 6) | (m_ev << 5) | m_open());
      8'h40:   return 32'(m_cnt);
      8'h60:   return 32'(m_per);
      8'h70:   return 32'(m_win);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_tick(logic s, logic w, logic [7:0] a, logic [31:0] d);
    int wr, tmo, pre, clr, good, bad, badpre;
    int n_cnt, n_armed, n_blank;
    wr     = (s && m_blank == 0 && w) ? 1 : 0;
    tmo    = (m_en != 0 && m_cnt >= m_per) ? 1 : 0;
    pre    = (wr != 0 && a == 8'h10 && m_en != 0) ? 1 : 0;
    clr    = (wr != 0 && a == 8'h20 && m_en != 0) ? 1 : 0;
    good   = (clr != 0 && d[7:0] == 8'h08 && m_armed != 0 && m_open() != 0) ? 1 : 0;
    bad    = (clr != 0 && good == 0) ? 1 : 0;
    badpre = (pre != 0 && d[15:8] != 8'h40) ? 1 : 0;
    if (m_en == 0 || good != 0 || tmo != 0) n_cnt = 0; else n_cnt = m_cnt + 1;
    if (m_en == 0 || tmo != 0 || clr != 0) n_armed = 0;
    else if (pre != 0) n_armed = (badpre == 0) ? 1 : 0;
    else n_armed = m_armed;
    n_blank = (wr != 0 && a == 8'h00 && m_en != 0 && !d[15]) ? 1 : 0;
    if (wr != 0 && a == 8'h30) begin
      if (d[7]) m_b1 = 0;
      if (d[6]) m_b2 = 0;
      if (d[5]) m_ev = 0;
    end
    if (badpre != 0) m_b1 = 1;
    if (bad != 0) m_b2 = 1;
    if (bad != 0 || tmo != 0) m_ev = 1;
    m_rq = (bad != 0 || tmo != 0) ? 1 : 0;
    if (wr != 0 && a == 8'h00) m_en = d[15] ? 1 : 0;
    if (wr != 0 && a == 8'h60) m_per = int'(d);
    if (wr != 0 && a == 8'h70) m_win = int'(d);
    m_cnt = n_cnt;
    m_armed = n_armed;
    m_blank = n_blank;
  endtask

  task automatic step(logic s, logic w, logic [7:0] a, logic [31:0] d, string tag);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    #1;
    check(tag, "rst_req", 32'(rst_req), 32'(m_rq));
    if (s && !w) check(tag, "rdata", bus_rdata, (m_blank != 0) ? 32'h0 : m_read(a));
    @(posedge clk);
    model_tick(s, w, a, d);
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d, string tag);
    step(1'b1, 1'b1, a, d, tag);
  endtask

  task automatic rd_reg(logic [7:0] a, string tag);
    step(1'b1, 1'b0, a, 32'h0, tag);
  endtask

  task automatic watch(int n, logic [7:0] a, string tag);
    for (int i = 0; i < n; i++) rd_reg(a, tag);
  endtask

  initial begin
    m_en = 0; m_cnt = 0; m_per = P_DEF; m_win = W_DEF; m_armed = 0;
    m_b1 = 0; m_b2 = 0; m_ev = 0; m_rq = 0; m_blank = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd_reg(8'h00, "R1"); rd_reg(8'h40, "R1"); rd_reg(8'h30, "R1");
    rd_reg(8'h60, "R1"); rd_reg(8'h70, "R1");
    // R11 programming and read-only counter
    wr_reg(8'h60, 32'd20, "R11"); wr_reg(8'h70, 32'd8, "R11");
    rd_reg(8'h60, "R11"); rd_reg(8'h70, "R11");
    wr_reg(8'h40, 32'd5, "R11"); rd_reg(8'h40, "R11");
    // R10 keys ignored while off
    wr_reg(8'h10, 32'h4000, "R10"); wr_reg(8'h20, 32'h08, "R10");
    rd_reg(8'h30, "R10"); rd_reg(8'h30, "R10");
    // R2 enable and counting
    wr_reg(8'h00, 32'h8000, "R2"); rd_reg(8'h00, "R2");
    watch(6, 8'h40, "R2");
    // R4 window opening
    watch(5, 8'h30, "R4");
    // R6 good sequence inside window
    wr_reg(8'h10, 32'h4000, "R6"); wr_reg(8'h20, 32'h08, "R6");
    rd_reg(8'h40, "R6"); rd_reg(8'h30, "R6");
    // R7 clear with window closed after arming
    wr_reg(8'h10, 32'h4000, "R7"); wr_reg(8'h20, 32'h08, "R7");
    rd_reg(8'h30, "R7");
    // R9 write-one-to-clear
    wr_reg(8'h30, 32'hE0, "R9"); rd_reg(8'h30, "R9");
    // R5 wrong arming key
    wr_reg(8'h10, 32'h1200, "R5"); rd_reg(8'h30, "R5");
    wr_reg(8'h30, 32'h80, "R9");
    watch(2, 8'h30, "R4");
    // R7 clear without arming, inside window
    wr_reg(8'h20, 32'h08, "R7"); rd_reg(8'h30, "R7");
    wr_reg(8'h30, 32'h60, "R9");
    // R7 wrong clear key after arming
    wr_reg(8'h10, 32'h4000, "R7"); wr_reg(8'h20, 32'h09, "R7");
    rd_reg(8'h30, "R7"); wr_reg(8'h30, 32'hE0, "R9");
    // R8 expiry
    watch(8, 8'h40, "R8");
    watch(3, 8'h30, "R8");
    watch(3, 8'h40, "R8");
    // R3 disable, blanked cycle, held counter
    wr_reg(8'h00, 32'h0, "R3");
    wr_reg(8'h00, 32'h8000, "R3");
    rd_reg(8'h00, "R3");
    watch(4, 8'h40, "R3");
    // R10 keys ignored after disable
    wr_reg(8'h20, 32'h08, "R10"); rd_reg(8'h30, "R10");
    step(1'b0, 1'b0, 8'h00, 32'h0, "R8");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule